// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block runs a fixed three-stage self-test once reset is released. The first stage reads every word of a small read-only table and sums the words. The second stage writes a generated pattern into a small RAM and reads it back. The third stage watches an external input until it has stayed high for a set number of consecutive cycles.

Each stage ends with a one-cycle result strobe. The strobe carries a test identifier and a pass/fail code, and goes to a separate status-signalling block. The sequencer then waits for that block to acknowledge the strobe before it starts the next stage. Table contents, expected sum, RAM pattern, input mask and hold length are all parameters.

Top module: `mem_selftest_seq`

## Requirements
- R1: The reset `rst_n` is synchronous and active low. While it is 0, `res_valid` stays 0. Releasing it to 1 starts the sequence with the table stage.
- R2: Table stage. Word i of the table equals ROM_SEED + i*ROM_STEP (modulo 2^32) for i = 0 .. ROM_WORDS-1. The words are added modulo 2^32 and the total is compared with EXP_SUM. The strobe reports test id 0 with code 2'b01 when the total matches and code 2'b10 when it does not.
- R3: RAM stage. Twelve 32-bit words are written to RAM and then read back at indices 0 to 11 in that order. The strobe reports test id 1. The code is 2'b01 only if all twelve read-back words equal the words written, and 2'b10 otherwise.
- R4: Hold stage. The input passes through two flops and is ANDed with PIN_MASK. Each masked 1 increments a counter and each masked 0 clears it. When the counter reaches HOLD_LIMIT, the strobe reports test id 2 with code 2'b01. Suppose the input rises between two edges and then stays high. Counting the first edge after the rise as edge 1, `res_valid` is 1 just after edge HOLD_LIMIT+3.
- R5: A run of HOLD_LIMIT-1 or fewer consecutive high samples produces no strobe. Any low sample restarts the count from zero.
- R6: Strobes come strictly in the order test id 0, 1, 2, one each. After the hold pass, no further strobe occurs whatever the input does.
- R7: `res_valid` is high for exactly one cycle per result.
- R8: After a strobe, no further strobe occurs and the next stage does not start until `res_ack` has been seen high. The acknowledge may come in the strobe cycle or in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous input watched by the hold stage |
| res_ack | input | 1 | Acknowledge from the status-signalling block |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 2'b01 pass, 2'b10 fail |
| res_test | output | 2 | Test id: 0 table, 1 RAM, 2 hold |

## Verification
A corrupted accumulator or a wrong table address appears as the wrong code on the first strobe, a few cycles after reset. A bad RAM address, data pattern or read-latency alignment flips the second code to fail. An off-by-one in the synchronizer or the hold counter moves the third strobe away from edge HOLD_LIMIT+3. A counter that fails to clear on a low sample produces a strobe after glitchy runs that should never report. A broken handshake shows as a strobe before the acknowledge, a strobe held for more than one cycle, or strobes out of order.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [2:0] {
    ST_ROM, ST_RAMW, ST_RAMR, ST_HOLD, ST_WAIT, ST_END
  } mst_state_t;

  localparam logic [1:0] CODE_PASS = 2'b01;
  localparam logic [1:0] CODE_FAIL = 2'b10;
  localparam logic [1:0] TID_ROM   = 2'd0;
  localparam logic [1:0] TID_RAM   = 2'd1;
  localparam logic [1:0] TID_HOLD  = 2'd2;
endpackage

// File: rtl/mst_rom.sv
module mst_rom #(
  parameter int          DATA_W = 32,
  parameter int          WORDS  = 8,
  parameter logic [DATA_W-1:0] SEED = '0,
  parameter logic [DATA_W-1:0] STEP = '0,
  localparam int         AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] q
);
  // table content computed from its index; registered read
  always_ff @(posedge clk) begin
    q <= SEED + STEP * DATA_W'(addr);
  end
endmodule

// File: rtl/mst_ram.sv
module mst_ram #(
  parameter int  DATA_W = 32,
  parameter int  WORDS  = 12,
  localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/mst_hold.sv
module mst_hold #(
  parameter int   LIMIT    = 20459,
  parameter logic PIN_MASK = 1'b1,
  localparam int  CW       = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pin_in,
  output logic hit
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic          masked;

  assign masked = s2 & PIN_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      if (!en || !masked) cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
    end
  end

  assign hit = en && (cnt == LIM);
endmodule

// File: rtl/mem_selftest_seq.sv
module mem_selftest_seq
  import mst_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ROM_WORDS  = 8,
  parameter logic [31:0] ROM_SEED   = 32'h1000_0001,
  parameter logic [31:0] ROM_STEP   = 32'h0101_0101,
  parameter logic [31:0] EXP_SUM    = 32'h9C1C_1C24,
  parameter int          RAM_WORDS  = 12,
  parameter logic [31:0] RAM_BASE   = 32'hA5C3_0F00,
  parameter logic [31:0] RAM_STEP   = 32'h1357_9BDF,
  parameter int          HOLD_LIMIT = 20459,
  parameter logic        PIN_MASK   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       res_ack,
  output logic       res_valid,
  output logic [1:0] res_code,
  output logic [1:0] res_test
);
  localparam int ROM_AW = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1;
  localparam int RAM_AW = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1;
  localparam int MAXW   = (ROM_WORDS > RAM_WORDS) ? ROM_WORDS : RAM_WORDS;
  localparam int IDX_W  = $clog2(MAXW + 1) + 1;
  localparam logic [IDX_W-1:0] ROM_END  = IDX_W'(ROM_WORDS);
  localparam logic [IDX_W-1:0] RAM_END  = IDX_W'(RAM_WORDS);
  localparam logic [IDX_W-1:0] RAM_LAST = IDX_W'(RAM_WORDS - 1);

  mst_state_t        state, after;
  logic [IDX_W-1:0]  idx, chk_idx;
  logic              rd_v, mism;
  logic [DATA_W-1:0] acc, rom_q, ram_q, ram_wdata;
  logic              ram_we, hold_hit;

  function automatic logic [DATA_W-1:0] ram_pat(input logic [IDX_W-1:0] i);
    return DATA_W'(RAM_BASE) + DATA_W'(RAM_STEP) * DATA_W'(i);
  endfunction

  assign ram_we    = (state == ST_RAMW);
  assign ram_wdata = ram_pat(idx);

  mst_rom #(.DATA_W(DATA_W), .WORDS(ROM_WORDS),
            .SEED(DATA_W'(ROM_SEED)), .STEP(DATA_W'(ROM_STEP))) u_rom (
    .clk(clk), .addr(idx[ROM_AW-1:0]), .q(rom_q));

  mst_ram #(.DATA_W(DATA_W), .WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .we(ram_we), .addr(idx[RAM_AW-1:0]),
    .wdata(ram_wdata), .q(ram_q));

  mst_hold #(.LIMIT(HOLD_LIMIT), .PIN_MASK(PIN_MASK)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(state == ST_HOLD),
    .pin_in(pin_in), .hit(hold_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_ROM;
      after     <= ST_ROM;
      idx       <= '0;
      chk_idx   <= '0;
      rd_v      <= 1'b0;
      mism      <= 1'b0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_code  <= 2'b00;
      res_test  <= 2'b00;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_ROM: begin
          if (rd_v) acc <= acc + rom_q;
          if (idx < ROM_END) begin
            idx  <= idx + 1'b1;
            rd_v <= 1'b1;
          end else begin
            rd_v <= 1'b0;
            if (!rd_v) begin
              res_valid <= 1'b1;
              res_test  <= TID_ROM;
              res_code  <= (acc == DATA_W'(EXP_SUM)) ? CODE_PASS : CODE_FAIL;
              after     <= ST_RAMW;
              state     <= ST_WAIT;
            end
          end
        end
        ST_RAMW: begin
          if (idx == RAM_LAST) begin
            idx   <= '0;
            mism  <= 1'b0;
            state <= ST_RAMR;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RAMR: begin
          if (rd_v && (ram_q != ram_pat(chk_idx))) mism <= 1'b1;
          if (idx < RAM_END) begin
            chk_idx <= idx;
            idx     <= idx + 1'b1;
            rd_v    <= 1'b1;
          end else begin
            rd_v <= 1'b0;
            if (!rd_v) begin
              res_valid <= 1'b1;
              res_test  <= TID_RAM;
              res_code  <= mism ? CODE_FAIL : CODE_PASS;
              after     <= ST_HOLD;
              state     <= ST_WAIT;
            end
          end
        end
        ST_HOLD: begin
          if (hold_hit) begin
            res_valid <= 1'b1;
            res_test  <= TID_HOLD;
            res_code  <= CODE_PASS;
            after     <= ST_END;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (res_ack) begin
            state <= after;
            idx   <= '0;
            rd_v  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mst_chk.sv
module mst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic [1:0] res_code,
  input logic [1:0] res_test,
  input logic       res_ack
);
  logic [1:0] nxt_test;
  logic       pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_test <= 2'd0;
      pending  <= 1'b0;
    end else begin
      if (res_valid && nxt_test != 2'd3) nxt_test <= nxt_test + 2'd1;
      pending <= (pending | res_valid) & ~res_ack;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !res_valid);

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_code == 2'b01 || res_code == 2'b10));

  // R6
  test_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_test == nxt_test && nxt_test != 2'd3));

  // R8
  await_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !pending);

  // R4
  hold_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_test == 2'd2) |-> res_code == 2'b01);
endmodule

bind mem_selftest_seq mst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_code(res_code),
  .res_test(res_test), .res_ack(res_ack));

// File: tb/sim_mem_selftest_seq.sv
`timescale 1ns/1ps
module sim_mem_selftest_seq;
  localparam int          ROM_WORDS = 8;
  localparam logic [31:0] SEED      = 32'h1000_0001;
  localparam logic [31:0] STEP      = 32'h0101_0101;
  localparam logic [31:0] SUM0      = 32'h9C1C_1C24;
  localparam logic [31:0] SUM1      = 32'h9C1C_1C25;
  localparam int          LIM0      = 20459;
  localparam int          LIM1      = 6;

  logic clk = 1'b0;
  logic rst0_n = 1'b0, rst1_n = 1'b0, pin = 1'b0, ack = 1'b0, sel = 1'b0;
  logic       v0, v1, v;
  logic [1:0] c0, c1, c, t0, t1, t;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mem_selftest_seq #(.EXP_SUM(SUM0), .HOLD_LIMIT(LIM0)) u0 (
    .clk(clk), .rst_n(rst0_n), .pin_in(pin), .res_ack(ack),
    .res_valid(v0), .res_code(c0), .res_test(t0));

  mem_selftest_seq #(.EXP_SUM(SUM1), .HOLD_LIMIT(LIM1)) u1 (
    .clk(clk), .rst_n(rst1_n), .pin_in(pin), .res_ack(ack),
    .res_valid(v1), .res_code(c1), .res_test(t1));

  assign v = sel ? v1 : v0;
  assign c = sel ? c1 : c0;
  assign t = sel ? t1 : t0;

  function automatic logic [31:0] table_sum();
    logic [31:0] s = '0;
    for (int i = 0; i < ROM_WORDS; i++) s = s + SEED + STEP * 32'(i);
    return s;
  endfunction

  task automatic chk(input string req, input logic ok,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (v) seen++;
    end
    chk(req, seen == 0, seen, 0);
  endtask

  task automatic get_strobe(input int limit, input string req,
                            output logic [1:0] code, output logic [1:0] tst);
    int k = 0;
    logic got = 1'b0;
    code = 2'b00; tst = 2'b11;
    while (k < limit && !got) begin
      @(negedge clk);
      k++;
      if (v) begin got = 1'b1; code = c; tst = t; end
    end
    chk({req, " strobe seen"}, got, k, limit);
    @(negedge clk);
    chk("R7 strobe one cycle", !v, v, 0);
  endtask

  task automatic give_ack();
    idle($urandom_range(1, 40), "R8 no strobe before ack");
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic hold_run(input int lim);
    int k = 0;
    logic got = 1'b0;
    pin = 1'b1;
    while (k < lim + 10 && !got) begin
      @(negedge clk);
      k++;
      if (v) got = 1'b1;
    end
    chk("R4 hold strobe edge", got && k == lim + 3, k, lim + 3);
    chk("R4 hold test id", t == 2'd2, t, 2);
    chk("R4 hold code", c == 2'b01, c, 1);
  endtask

  logic [1:0] code, tst;
  logic [31:0] sum_exp;

  initial begin
    void'($urandom(32'd1234));
    sum_exp = table_sum();
    // R1: held in reset, no strobe
    idle(20, "R1 reset quiet");
    chk("R1 reset state", v0 == 1'b0, v0, 0);
    @(negedge clk); rst0_n = 1'b1;

    // R2 pass case
    get_strobe(100, "R2", code, tst);
    chk("R2 test id", tst == 2'd0, tst, 0);
    chk("R2 code", code == ((sum_exp == SUM0) ? 2'b01 : 2'b10), code,
        (sum_exp == SUM0) ? 1 : 2);
    give_ack();
    // R3
    get_strobe(200, "R3", code, tst);
    chk("R3 test id", tst == 2'd1, tst, 1);
    chk("R3 code", code == 2'b01, code, 1);
    give_ack();
    idle(5, "R6 hold idle");
    // R5: long run below limit, then a gap restarts the count
    pin = 1'b1;
    idle(10000, "R5 partial run");
    pin = 1'b0;
    idle(3, "R5 gap");
    hold_run(LIM0);
    give_ack();
    // R6: nothing more after the hold pass
    pin = 1'b0; idle(20, "R6 after end low");
    pin = 1'b1; idle(80, "R6 after end high");
    pin = 1'b0;

    // second instance: wrong expected sum, short hold limit
    sel = 1'b1;
    @(negedge clk); rst1_n = 1'b1;
    get_strobe(100, "R2 fail", code, tst);
    chk("R2 fail test id", tst == 2'd0, tst, 0);
    chk("R2 fail code", code == ((sum_exp == SUM1) ? 2'b01 : 2'b10), code,
        (sum_exp == SUM1) ? 1 : 2);
    give_ack();
    get_strobe(200, "R3 second", code, tst);
    chk("R3 second code", code == 2'b01 && tst == 2'd1, {tst, code}, 5);
    give_ack();
    idle(5, "R6 idle");
    // R5: random glitchy runs shorter than the limit
    for (int r = 0; r < 40; r++) begin
      pin = 1'b1;
      repeat ($urandom_range(1, LIM1 - 1)) @(negedge clk);
      pin = 1'b0;
      repeat ($urandom_range(1, 3)) @(negedge clk);
      chk("R5 random short run", !v, v, 0);
    end
    // R5 boundary: exactly LIM1-1 high samples
    pin = 1'b1; idle(LIM1 - 1, "R5 limit-1 run");
    pin = 1'b0; idle(4, "R5 limit-1 gap");
    hold_run(LIM1);
    give_ack();
    idle(50, "R6 second end");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule